// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Slot Limit and Parking

This block decides which of several bus masters may drive one slave port of a multi-master interconnect. Every master presents a request flag and a burst-active flag. The arbiter grants the slave to at most one master through a one-hot grant vector. The grant is registered, so it appears one clock after the decision.

A configuration input selects the arbitration style. In round-robin mode the search for a winner starts at the master after the one granted most recently. In fixed-priority mode each master's 2-bit level decides, and a higher value wins. An 8-bit slot limit caps the number of burst cycles that an owner may use while another master is waiting. A parking policy chooses which master, if any, keeps the grant while nobody is requesting. All configuration arrives on plain input ports, and the arbiter may read it on any cycle.

The controller has three states:
- `ST_IDLE`: no grant is driven.
- `ST_PARK`: a parking master holds the grant but has no traffic.
- `ST_HOLD`: an owner holds the grant and its slot counter runs.

The transitions are:
- Idle-to-hold: a request is present.
- Idle-to-park: there is no request and the parking policy names a master.
- Park-to-hold: the parked master raises its request or burst flag.
- Park-to-hold: another master wins arbitration.
- Park-to-idle: the parking policy now names nobody.
- Hold-to-hold: the owner keeps the grant, or another master wins at a burst boundary or at slot expiry.
- Hold-to-park: the owner finishes with no other request, and the policy names a master.
- Hold-to-idle: the owner finishes with no other request, and the policy names nobody.

Top module: `slave_port_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, gnt_o is all zero and no master is granted.
- R2: gnt_o never has more than one bit set.
- R3: When arb_mode_i is not 1 (round-robin), the winner is the first requesting master found by searching upward from the index after the most recently granted master. The search wraps from index N-1 to 0.
- R4: When arb_mode_i is 1 (fixed priority), the winner is the requester with the largest 2-bit level. Master i's level is prio_i[2i+1:2i]. Equal levels go to the lowest index. The values 0, 2 and 3 all select round-robin.
- R5: A granted master keeps the grant on every cycle in which its req_i or burst_i bit is high, unless R6 applies. The grant moves only when that master drops both bits.
- R6: Every cycle of a grant in which the owner's burst_i bit is high counts against slot_limit_i. The arbiter re-arbitrates at the edge that completes the slot_limit_i-th counted cycle if another master is requesting. The owner is left out of that arbitration.
- R7: A slot_limit_i of 0 disables preemption. The owner keeps the grant for as long as R5 holds.
- R8: The slot count restarts at zero on every new grant. Cycles in which the owner has only req_i high, with burst_i low, are not counted.
- R9: With park_mode_i equal to 0 and no requester, the grant drops to all zero one cycle after the owner releases.
- R10: With park_mode_i equal to 1 and no requester, the master granted most recently keeps the grant. Before any grant has been made, this is master 0.
- R11: With park_mode_i equal to 2 and no requester, the grant goes to master park_idx_i. Values of park_idx_i of N or above are treated like mode 0, and park_mode_i equal to 3 is also treated like mode 0.
- R12: A parked master that raises req_i or burst_i keeps its grant with no gap, even if a master with a higher priority requests in the same cycle.
- R13: From an all-zero grant, a request produces a grant to one of the requesters on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request flag per master |
| burst_i | input | N | Burst-in-progress flag per master |
| arb_mode_i | input | 2 | 1 selects fixed priority; any other value selects round-robin |
| prio_i | input | 2*N | 2-bit priority level per master, master i in bits [2i+1:2i] |
| slot_limit_i | input | SW | Maximum counted burst cycles while others wait; 0 means no limit |
| park_mode_i | input | 2 | 0 no parking, 1 park the last owner, 2 park a fixed master, 3 no parking |
| park_idx_i | input | PIW | Master index parked in mode 2 |
| gnt_o | output | N | One-hot grant, registered |

## Verification
Several properties are checked on every clock:
- The grant is never more than one-hot.
- An active owner keeps its grant whenever the slot limit is 0.
- An all-zero grant with a request pending leads to a grant to one of those requesters on the next cycle.
- An idle slave empties the grant when parking is off, and moves the grant to the chosen master under fixed parking.

Some behaviours depend on history and can only be shown by the bench's scenarios:
- The round-robin search order and its wrap-around.
- Breaking priority ties in fixed-priority mode.
- The exact edge at which a slot expires.
- Leaving the owner out of the re-arbitration after expiry.
- Counting only burst cycles, and restarting the count on each new grant.
- Parking on the last owner.
- A parked master keeping its grant against a higher-priority request.

// File: rtl/spa_pkg.sv
package spa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PARK = 2'd1,
        ST_HOLD = 2'd2
    } spa_state_e;

    localparam logic [1:0] PM_NONE  = 2'd0;
    localparam logic [1:0] PM_LAST  = 2'd1;
    localparam logic [1:0] PM_FIXED = 2'd2;

    localparam logic [1:0] AM_FIXED = 2'd1;

endpackage

// File: rtl/spa_pick.sv
// Combinational winner selection: round-robin or per-master fixed priority.
module spa_pick #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]   cand,
    input  logic [2*N-1:0] prio,
    input  logic           fixed_mode,
    input  logic [IW-1:0]  last_idx,
    output logic           found,
    output logic [IW-1:0]  win_idx
);

    logic          rr_found;
    logic [IW-1:0] rr_idx;
    logic          fx_found;
    logic [IW-1:0] fx_idx;
    logic [1:0]    fx_best;

    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] base, input int off);
        int s;
        s = int'(base) + off;
        if (s >= N) s = s - N;
        return IW'(s);
    endfunction

    // Round-robin: scan upward starting one past the previous winner.
    always_comb begin
        rr_found = 1'b0;
        rr_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            if (!rr_found && cand[wrap_add(last_idx, k)]) begin
                rr_found = 1'b1;
                rr_idx   = wrap_add(last_idx, k);
            end
        end
    end

    // Fixed priority: strictly greater level replaces, so ties keep the lower index.
    always_comb begin
        fx_found = 1'b0;
        fx_idx   = '0;
        fx_best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!fx_found || (prio[2*i +: 2] > fx_best))) begin
                fx_found = 1'b1;
                fx_idx   = IW'(i);
                fx_best  = prio[2*i +: 2];
            end
        end
    end

    always_comb begin
        found   = fixed_mode ? fx_found : rr_found;
        win_idx = fixed_mode ? fx_idx   : rr_idx;
    end

endmodule

// File: rtl/spa_slot.sv
// Burst cycle counter with expiry detection.
module spa_slot #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          reload_first,
    input  logic          count_en,
    input  logic [SW-1:0] limit,
    output logic          expire
);

    localparam logic [SW-1:0] CNT_MAX = {SW{1'b1}};

    logic [SW-1:0] cnt_q;
    logic [SW:0]   used;

    always_comb begin
        used   = {1'b0, cnt_q} + (SW+1)'(1);
        expire = (limit != '0) && count_en && (used >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= reload_first ? SW'(1) : '0;
        end else if (count_en && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + SW'(1);
        end
    end

endmodule

// File: rtl/spa_park.sv
// Resolves the parking target from the parking policy.
module spa_park #(
    parameter int N   = 9,
    parameter int IW  = 4,
    parameter int PIW = 4
) (
    input  logic [1:0]     mode,
    input  logic [PIW-1:0] fixed_idx,
    input  logic [IW-1:0]  last_idx,
    output logic           valid,
    output logic [IW-1:0]  idx
);

    import spa_pkg::*;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        unique case (mode)
            PM_LAST: begin
                valid = 1'b1;
                idx   = last_idx;
            end
            PM_FIXED: begin
                valid = (int'(fixed_idx) < N);
                idx   = IW'(fixed_idx);
            end
            default: begin
                valid = 1'b0;
                idx   = '0;
            end
        endcase
    end

endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
    import spa_pkg::*;
#(
    parameter int N   = 9,
    parameter int SW  = 8,
    parameter int PIW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     burst_i,
    input  logic [1:0]       arb_mode_i,
    input  logic [2*N-1:0]   prio_i,
    input  logic [SW-1:0]    slot_limit_i,
    input  logic [1:0]       park_mode_i,
    input  logic [PIW-1:0]   park_idx_i,
    output logic [N-1:0]     gnt_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    spa_state_e    state_q, state_d;
    logic [IW-1:0] own_q, own_d;
    logic [IW-1:0] last_q;

    logic [N-1:0]  own_vec;
    logic          own_act;
    logic          own_burst;
    logic [N-1:0]  others;
    logic [N-1:0]  cand;

    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          park_valid;
    logic [IW-1:0] park_idx;

    logic          slot_reload;
    logic          slot_first;
    logic          slot_count;
    logic          slot_expire;

    always_comb begin
        own_vec   = N'(1) << own_q;
        own_act   = |(own_vec & (req_i | burst_i));
        own_burst = |(own_vec & burst_i);
        others    = req_i & ~own_vec;
        slot_count = (state_q == ST_HOLD) && own_burst;
        // During an active hold the only arbitration is a preemption, which excludes the owner.
        cand      = ((state_q == ST_HOLD) && own_act) ? others : req_i;
    end

    spa_pick #(.N(N), .IW(IW)) u_pick (
        .cand       (cand),
        .prio       (prio_i),
        .fixed_mode (arb_mode_i == AM_FIXED),
        .last_idx   (last_q),
        .found      (pick_found),
        .win_idx    (pick_idx)
    );

    spa_park #(.N(N), .IW(IW), .PIW(PIW)) u_park (
        .mode      (park_mode_i),
        .fixed_idx (park_idx_i),
        .last_idx  (last_q),
        .valid     (park_valid),
        .idx       (park_idx)
    );

    spa_slot #(.SW(SW)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload       (slot_reload),
        .reload_first (slot_first),
        .count_en     (slot_count),
        .limit        (slot_limit_i),
        .expire       (slot_expire)
    );

    // Next-state decision.
    always_comb begin
        logic do_arb;
        do_arb      = 1'b0;
        state_d     = state_q;
        own_d       = own_q;
        slot_reload = 1'b0;
        slot_first  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                do_arb = 1'b1;
            end
            ST_PARK: begin
                if (own_act) begin
                    state_d     = ST_HOLD;
                    slot_reload = 1'b1;
                    slot_first  = own_burst;
                end else begin
                    do_arb = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!own_act) begin
                    do_arb = 1'b1;
                end else if (slot_expire && (others != '0)) begin
                    do_arb = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (do_arb) begin
            if (pick_found) begin
                state_d     = ST_HOLD;
                own_d       = pick_idx;
                slot_reload = 1'b1;
                slot_first  = 1'b0;
            end else if (park_valid) begin
                state_d = ST_PARK;
                own_d   = park_idx;
            end else begin
                state_d = ST_IDLE;
                own_d   = '0;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            own_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            if (state_d == ST_HOLD) begin
                last_q <= own_d;
            end
        end
    end

    // Output decode.
    always_comb begin
        gnt_o = (state_q == ST_IDLE) ? '0 : own_vec;
    end

endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
    parameter int N   = 9,
    parameter int SW  = 8,
    parameter int PIW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   req_i,
    input logic [N-1:0]   burst_i,
    input logic [SW-1:0]  slot_limit_i,
    input logic [1:0]     park_mode_i,
    input logic [PIW-1:0] park_idx_i,
    input logic [N-1:0]   gnt_o
);

    a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r5_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & (req_i | burst_i)) != '0) && (slot_limit_i == '0)
        |=> (gnt_o == $past(gnt_o)));

    a_r9_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) && ((gnt_o & burst_i) == '0) && (park_mode_i == 2'd0)
        |=> (gnt_o == '0));

    a_r11_fixed_park: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) && ((gnt_o & burst_i) == '0) && (park_mode_i == 2'd2)
        && (int'(park_idx_i) < N)
        |=> (gnt_o == (N'(1) << $past(park_idx_i))));

    a_r13_idle_to_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) && (req_i != '0)
        |=> $onehot(gnt_o) && ((gnt_o & $past(req_i)) != '0));

endmodule

bind slave_port_arbiter spa_checker #(.N(N), .SW(SW), .PIW(PIW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .burst_i      (burst_i),
    .slot_limit_i (slot_limit_i),
    .park_mode_i  (park_mode_i),
    .park_idx_i   (park_idx_i),
    .gnt_o        (gnt_o)
);

// File: tb/slave_port_arbiter_tb.sv
module slave_port_arbiter_tb;

    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] burst = '0;
    logic [1:0]   arb_mode = 2'd0;
    logic [2*N-1:0] prio = '0;
    logic [7:0]   slot_limit = 8'd0;
    logic [1:0]   park_mode = 2'd0;
    logic [3:0]   park_idx = 4'd0;
    logic [N-1:0] gnt;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // reference model state: 0 idle, 1 parked, 2 holding
    int m_state = 0;
    int m_own = 0;
    int m_last = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    slave_port_arbiter #(.N(N), .SW(8), .PIW(4)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .burst_i      (burst),
        .arb_mode_i   (arb_mode),
        .prio_i       (prio),
        .slot_limit_i (slot_limit),
        .park_mode_i  (park_mode),
        .park_idx_i   (park_idx),
        .gnt_o        (gnt)
    );

    function automatic int lvl(input int i);
        return int'(prio[2*i +: 2]);
    endfunction

    function automatic int choose(input int excl);
        int best;
        best = -1;
        if (arb_mode == 2'd1) begin
            for (int i = 0; i < N; i++)
                if (req[i] && i != excl && (best < 0 || lvl(i) > lvl(best))) best = i;
        end else begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (m_last + k) % N;
                if (best < 0 && req[c] && c != excl) best = c;
            end
        end
        return best;
    endfunction

    task automatic model_step();
        bit act;
        bit arb;
        int excl;
        int w;
        int used;
        bit rivals;
        act = (m_state != 0) && (req[m_own] || burst[m_own]);
        arb = 1'b0;
        excl = -1;
        rivals = 1'b0;
        for (int i = 0; i < N; i++) if (req[i] && i != m_own) rivals = 1'b1;
        if (m_state == 0) arb = 1'b1;
        else if (m_state == 1) begin
            if (act) begin
                m_state = 2; m_last = m_own; m_cnt = burst[m_own] ? 1 : 0;
            end else arb = 1'b1;
        end else begin
            if (!act) arb = 1'b1;
            else if (burst[m_own]) begin
                used = m_cnt + 1;
                if (slot_limit != 0 && used >= int'(slot_limit) && rivals) begin
                    arb = 1'b1; excl = m_own;
                end
                m_cnt = (used > 255) ? 255 : used;
            end
        end
        if (arb) begin
            w = choose(excl);
            if (w >= 0) begin
                m_state = 2; m_own = w; m_last = w; m_cnt = 0;
            end else if (park_mode == 2'd1) begin
                m_state = 1; m_own = m_last;
            end else if (park_mode == 2'd2 && int'(park_idx) < N) begin
                m_state = 1; m_own = int'(park_idx);
            end else begin
                m_state = 0; m_own = 0;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_own = 0; m_last = 0; m_cnt = 0;
        end else begin
            model_step();
        end
    end

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        logic [N-1:0] exp;
        if (!done) begin
            exp = (m_state == 0) ? '0 : (N'(1) << m_own);
            n_cmp++;
            if (gnt !== exp) begin
                n_bad++;
                $display("FAIL %s model: gnt=%b expected=%b at %0t", cur_tag, gnt, exp, $time);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [N-1:0] exp, input string tag);
        n_cmp++;
        if (gnt !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected=%b at %0t", tag, gnt, exp, $time);
        end
    endtask

    task automatic set_lvl(input int i, input logic [1:0] v);
        prio[2*i +: 2] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset
        cur_tag = "R1";
        repeat (3) tick();
        chk('0, "R1");
        rst_n = 1'b1;
        tick(); chk('0, "R1");
        cur_tag = "R9";
        tick(); chk('0, "R9");

        // R13 and R5: first grant, then hold by request
        cur_tag = "R13";
        req = 9'b000001000;
        tick(); chk(9'b000001000, "R13");
        cur_tag = "R5";
        repeat (4) begin tick(); chk(9'b000001000, "R5"); end
        req = '0;
        tick(); chk('0, "R9");

        // R3: round-robin after master 3, with wrap
        cur_tag = "R3";
        req = 9'b100100010;
        tick(); chk(9'b000100000, "R3");
        req[5] = 1'b0;
        tick(); chk(9'b100000000, "R3");
        req[8] = 1'b0;
        tick(); chk(9'b000000010, "R3");
        req = '0;
        tick(); chk('0, "R9");

        // R4: fixed priority, tie to lower index
        cur_tag = "R4";
        arb_mode = 2'd1;
        set_lvl(2, 2'd1); set_lvl(4, 2'd3); set_lvl(6, 2'd2); set_lvl(7, 2'd3);
        req = 9'b011010100;
        tick(); chk(9'b000010000, "R4");
        req[4] = 1'b0;
        tick(); chk(9'b010000000, "R4");
        req[7] = 1'b0;
        tick(); chk(9'b001000000, "R4");
        req[6] = 1'b0;
        tick(); chk(9'b000000100, "R4");
        req = '0;
        tick(); chk('0, "R4");
        // arb_mode 2 falls back to round-robin (last = 2)
        arb_mode = 2'd2;
        set_lvl(0, 2'd3);
        req = 9'b010000001;
        tick(); chk(9'b010000000, "R4");
        req = '0;
        tick(); chk('0, "R4");

        // R6: slot expiry, owner excluded even with top priority
        cur_tag = "R6";
        arb_mode = 2'd1;
        set_lvl(1, 2'd3); set_lvl(6, 2'd0);
        slot_limit = 8'd4;
        req = 9'b000000010; burst = 9'b000000010;
        tick(); chk(9'b000000010, "R6");
        req[6] = 1'b1;
        repeat (3) begin tick(); chk(9'b000000010, "R6"); end
        tick(); chk(9'b001000000, "R6");
        req = '0; burst = '0;
        tick(); chk('0, "R6");

        // R8: only burst cycles count; count restarts on a new grant
        cur_tag = "R8";
        arb_mode = 2'd0;
        slot_limit = 8'd3;
        req = 9'b000000100;
        tick(); chk(9'b000000100, "R8");
        req[5] = 1'b1;
        repeat (4) begin tick(); chk(9'b000000100, "R8"); end
        burst[2] = 1'b1;
        tick(); chk(9'b000000100, "R8");
        tick(); chk(9'b000000100, "R8");
        tick(); chk(9'b000100000, "R8");
        burst = 9'b000100000;
        tick(); chk(9'b000100000, "R8");
        tick(); chk(9'b000100000, "R8");
        tick(); chk(9'b000000100, "R8");
        req = '0; burst = '0;
        tick(); chk('0, "R8");

        // R7: limit 0 never preempts
        cur_tag = "R7";
        slot_limit = 8'd0;
        req = 9'b000001000; burst = 9'b000001000;
        tick(); chk(9'b000001000, "R7");
        req[0] = 1'b1;
        repeat (12) begin tick(); chk(9'b000001000, "R7"); end

        // R10: park on last owner
        cur_tag = "R10";
        park_mode = 2'd1;
        req = '0; burst = '0;
        tick(); chk(9'b000001000, "R10");
        repeat (3) begin tick(); chk(9'b000001000, "R10"); end

        // R11: fixed parking, out-of-range index, mode 3
        cur_tag = "R11";
        park_mode = 2'd2; park_idx = 4'd6;
        tick(); chk(9'b001000000, "R11");
        park_idx = 4'd12;
        tick(); chk('0, "R11");
        park_idx = 4'd6;
        tick(); chk(9'b001000000, "R11");
        park_mode = 2'd3;
        tick(); chk('0, "R11");

        // R12: parked master keeps grant against higher priority
        cur_tag = "R12";
        park_mode = 2'd2; park_idx = 4'd6;
        tick(); chk(9'b001000000, "R12");
        arb_mode = 2'd1;
        set_lvl(0, 2'd3); set_lvl(6, 2'd0);
        req = 9'b001000001;
        tick(); chk(9'b001000000, "R12");
        tick(); chk(9'b001000000, "R12");
        req[6] = 1'b0;
        tick(); chk(9'b000000001, "R12");
        req = '0;
        tick(); chk(9'b001000000, "R11");

        // R2: randomized traffic against the model
        cur_tag = "R2";
        for (int c = 0; c < 3000; c++) begin
            req   = N'($urandom) & N'($urandom);
            burst = N'($urandom) & N'($urandom) & N'($urandom);
            if ((c % 97) == 0) begin
                arb_mode   = 2'($urandom);
                prio       = (2*N)'($urandom);
                slot_limit = 8'($urandom % 6);
                park_mode  = 2'($urandom);
                park_idx   = 4'($urandom);
            end
            tick();
        end

        finish_run();
    end

endmodule